// File: doc/BRIEF.md
# I2C Slave Controller with Clock Stretching

This block is the slave side of an I2C port, working one byte at a time. It watches the open-drain SDA and SCL lines through synchronisers, finds START and STOP conditions, and decodes the address phase. The own address can be 7 or 10 bits wide. The general call address can be accepted, and an accept-all mode acknowledges every address. Once addressed, the block receives bytes and reports each one, or it shifts out the byte that the host supplies. The bus outputs are pull-low enables only.

Clock stretching is controlled by a release flag that the host can see. While the flag is clear, the slave holds SCL low, but it only starts to do so while SCL is already low. Hardware clears the flag at fixed points in each byte, and software sets it again to let the transfer go on. When stretch mode is on, software may also clear the flag to force a stretch. When stretch mode is off, software can only set the flag, and received data bytes no longer stop the bus.

Top module: `i2c_slave_stretch`

## Requirements
- R1: After reset, and on every cycle after `en` has been low, both pull-low enables are 0 and `rel` is 1. Disabling aborts any transfer, so the controller waits for a new START.
- R2: While `rel` is 1, `scl_oe` is 0 from the next clock cycle on.
- R3: `scl_oe` only rises after the synchronised SCL has been seen low. A stretch requested while SCL is high waits until SCL falls.
- R4: With `str_en`=1, a `rel_clr` pulse clears `rel` and a `rel_set` pulse sets it.
- R5: With `str_en`=0, `rel_clr` has no effect on `rel`. Only `rel_set` and hardware change it.
- R6: Hardware clears `rel` at the SCL falling edge that ends the ACK of every acknowledged address byte. It also clears `rel` before each byte the slave transmits, so SCL is stretched at each of these points until software sets `rel`.
- R7: After an acknowledged data byte is received, hardware clears `rel` only when `str_en`=1. When `str_en`=0, no stretch follows a received data byte.
- R8: In 7-bit mode, the first byte after START is matched as own_addr[6:0] in bits 7..1, with bit 0 as read (1) or write (0). On a match SDA is pulled low on the ninth clock. On a mismatch there is no ACK, and the bus is ignored until the next START or STOP.
- R9: In 10-bit mode, a write header 11110 followed by own_addr[9:8] and 0 is acknowledged. A second byte equal to own_addr[7:0] then completes the match, which is reported on `addr_hit`. After a repeated START, the same header with bit 0 set selects transmit. Any other second byte is not acknowledged.
- R10: With `gc_en`=1, the byte 0x00 is acknowledged and `gc_hit` pulses together with `addr_hit`. With `gc_en`=0, 0x00 is not acknowledged and `gc_hit` stays 0, unless `acc_all` accepts it.
- R11: With `acc_all`=1, every address byte is acknowledged, whatever `own_addr` holds.
- R12: In receive mode, `rx_byte` is loaded from the eight data bits, MSB first, and `rx_done` pulses at the eighth SCL rising edge. The byte is acknowledged. `rx_done` never pulses together with `addr_hit` or `tx_load`.
- R13: In transmit mode, `tx_load` pulses at the start of each byte, and `tx_byte` is sent MSB first. The value present while SCL is stretched is the one sent. A master ACK continues with another byte. A master NACK ends transmit, releases SDA and clears `rd_mode`.
- R14: A START in the middle of a byte aborts the transfer and restarts address decoding. A STOP returns the controller to waiting for an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable. When 0, the block resets and releases the bus |
| str_en | input | 1 | Stretch mode: software may clear `rel`, and received data bytes stretch |
| ten_bit | input | 1 | 1: 10-bit own address; 0: 7-bit |
| gc_en | input | 1 | Accept the general call address 0x00 |
| acc_all | input | 1 | Acknowledge every address |
| own_addr | input | 10 | Own slave address. Bits 6..0 are used in 7-bit mode |
| rel_set | input | 1 | Software write of 1 to the release flag (pulse) |
| rel_clr | input | 1 | Software write of 0 to the release flag (pulse) |
| tx_byte | input | 8 | Byte to transmit |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| rel | output | 1 | Release flag. 0 means SCL is being held |
| rd_mode | output | 1 | Slave is in transmit mode |
| rx_byte | output | 8 | Last received data byte |
| rx_done | output | 1 | Pulse: a data byte was received |
| tx_load | output | 1 | Pulse: a transmit byte has started |
| addr_hit | output | 1 | Pulse: the address matched |
| gc_hit | output | 1 | Pulse: the general call was accepted |

## Verification
Some rules must hold on every cycle whatever the traffic, and the assertions check those. They check that a set release flag lets SCL go by the next cycle, and that a stretch never starts while SCL is high. They check that disabling the block frees both lines and that a software clear does nothing while stretch mode is off. They also check that general-call pulses only come with an enabled, matched address, and that the event pulses never overlap. Other behaviours need a whole transfer to show, so only the bench scenarios can exercise them: address matching in both widths, the point in each byte where hardware clears the flag, the different stretch behaviour after received bytes in the two stretch modes, transmit ordering with ACK and NACK from the master, and aborts caused by a START in the middle of a byte.

// File: rtl/i2c_slave_stretch.sv
module i2c_slave_stretch #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       str_en,
  input  logic       ten_bit,
  input  logic       gc_en,
  input  logic       acc_all,
  input  logic [9:0] own_addr,
  input  logic       rel_set,
  input  logic       rel_clr,
  input  logic [7:0] tx_byte,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       rel,
  output logic       rd_mode,
  output logic [7:0] rx_byte,
  output logic       rx_done,
  output logic       tx_load,
  output logic       addr_hit,
  output logic       gc_hit
);
  typedef enum logic [2:0] {IDLE, ADDR, ADDR2, RX, TX} st_t;

  st_t st, nxt;
  logic [SYNC-1:0] scl_sy, sda_sy;
  logic scl_p, sda_p;
  logic [3:0] cnt;
  logic [7:0] sr, txsr;
  logic ackph, ack_ok, ten_sel, pend_addr, pend_rx, hw_clr;

  wire scl_s = scl_sy[SYNC-1];
  wire sda_s = sda_sy[SYNC-1];
  wire sta  = scl_s & scl_p & sda_p & ~sda_s;
  wire sto  = scl_s & scl_p & ~sda_p & sda_s;
  wire rise = scl_s & ~scl_p;
  wire fall = ~scl_s & scl_p;
  wire [7:0] b = {sr[6:0], sda_s};
  wire hdr_ok  = acc_all | (b[7:3] == 5'b11110 && b[2:1] == own_addr[9:8]);
  wire gc_byte = gc_en && b == 8'h00;
  wire hit7    = acc_all || b[7:1] == own_addr[6:0] || gc_byte;

  assign rd_mode = (st == TX);
  assign sda_oe  = ackph ? ack_ok : (st == TX && !txsr[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel    <= 1'b1;
      scl_oe <= 1'b0;
    end else if (!en) begin
      rel    <= 1'b1;
      scl_oe <= 1'b0;
    end else begin
      if (hw_clr)                rel <= 1'b0;
      else if (rel_set)          rel <= 1'b1;
      else if (rel_clr && str_en) rel <= 1'b0;
      scl_oe <= ~rel & (scl_oe | ~scl_s);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1; scl_p <= 1'b1; sda_p <= 1'b1;
      st <= IDLE; nxt <= IDLE; cnt <= '0; sr <= '0; txsr <= '1;
      ackph <= 1'b0; ack_ok <= 1'b0; ten_sel <= 1'b0;
      pend_addr <= 1'b0; pend_rx <= 1'b0; hw_clr <= 1'b0;
      rx_byte <= '0; rx_done <= 1'b0; tx_load <= 1'b0;
      addr_hit <= 1'b0; gc_hit <= 1'b0;
    end else if (!en) begin
      scl_sy <= '1; sda_sy <= '1; scl_p <= 1'b1; sda_p <= 1'b1;
      st <= IDLE; nxt <= IDLE; cnt <= '0; sr <= '0; txsr <= '1;
      ackph <= 1'b0; ack_ok <= 1'b0; ten_sel <= 1'b0;
      pend_addr <= 1'b0; pend_rx <= 1'b0; hw_clr <= 1'b0;
      rx_byte <= '0; rx_done <= 1'b0; tx_load <= 1'b0;
      addr_hit <= 1'b0; gc_hit <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[SYNC-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
      rx_done <= 1'b0; tx_load <= 1'b0; addr_hit <= 1'b0;
      gc_hit <= 1'b0; hw_clr <= 1'b0;
      if (sta || sto) begin
        st <= sta ? ADDR : IDLE;
        cnt <= '0; ackph <= 1'b0; ack_ok <= 1'b0;
        pend_addr <= 1'b0; pend_rx <= 1'b0; txsr <= '1;
        if (sto) ten_sel <= 1'b0;
      end else if (st != IDLE) begin
        if (st == TX && cnt == 4'd0 && !ackph && scl_oe) txsr <= tx_byte;
        if (rise) begin
          if (cnt < 4'd8) begin
            sr  <= b;
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              case (st)
                ADDR: begin
                  nxt <= IDLE;
                  if (!ten_bit || gc_byte) begin
                    if (hit7) begin
                      ack_ok <= 1'b1; addr_hit <= 1'b1; gc_hit <= gc_byte;
                      pend_addr <= 1'b1; nxt <= b[0] ? TX : RX;
                    end
                  end else if (hdr_ok && !b[0]) begin
                    ack_ok <= 1'b1; pend_addr <= 1'b1; nxt <= ADDR2;
                  end else if (hdr_ok && (ten_sel || acc_all)) begin
                    ack_ok <= 1'b1; addr_hit <= 1'b1; pend_addr <= 1'b1; nxt <= TX;
                  end
                end
                ADDR2: begin
                  if (acc_all || b == own_addr[7:0]) begin
                    ack_ok <= 1'b1; addr_hit <= 1'b1; pend_addr <= 1'b1;
                    ten_sel <= 1'b1; nxt <= RX;
                  end else begin
                    ten_sel <= 1'b0; nxt <= IDLE;
                  end
                end
                RX: begin
                  rx_byte <= b; rx_done <= 1'b1; ack_ok <= 1'b1;
                  pend_rx <= 1'b1; nxt <= RX;
                end
                default: ;
              endcase
            end
          end else if (cnt == 4'd8) begin
            cnt <= 4'd9;
            if (st == TX) nxt <= sda_s ? IDLE : TX;
          end
        end
        if (fall) begin
          if (cnt == 4'd8 && !ackph) begin
            ackph <= 1'b1;
          end else if (cnt == 4'd9) begin
            ackph <= 1'b0; ack_ok <= 1'b0; cnt <= '0; st <= nxt;
            hw_clr <= pend_addr | (pend_rx & str_en) | (nxt == TX);
            pend_addr <= 1'b0; pend_rx <= 1'b0;
            if (nxt == TX) begin
              txsr <= tx_byte; tx_load <= 1'b1;
            end else begin
              txsr <= '1;
            end
          end else if (st == TX && cnt != 4'd0 && cnt < 4'd8) begin
            txsr <= {txsr[6:0], 1'b1};
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_slave_stretch_chk.sv
module i2c_slave_stretch_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic str_en,
  input logic gc_en,
  input logic rel,
  input logic hw_clr,
  input logic scl_s,
  input logic scl_oe,
  input logic sda_oe,
  input logic gc_hit,
  input logic addr_hit,
  input logic rx_done,
  input logic tx_load
);
  assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !sda_oe && rel));

  assert_release_frees_scl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rel |=> !scl_oe);

  assert_stretch_only_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !$past(scl_s));

  assert_sw_clear_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!str_en && rel && !hw_clr) |=> rel);

  assert_gc_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gc_hit |-> ($past(gc_en) && addr_hit));

  assert_pulses_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_done, addr_hit, tx_load}));
endmodule

bind i2c_slave_stretch i2c_slave_stretch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .str_en(str_en), .gc_en(gc_en),
  .rel(rel), .hw_clr(hw_clr), .scl_s(scl_s), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .gc_hit(gc_hit), .addr_hit(addr_hit), .rx_done(rx_done), .tx_load(tx_load)
);

// File: tb/sim_i2c_slave_stretch.sv
module sim_i2c_slave_stretch;
  localparam int H = 20;
  localparam logic [6:0] OWN7 = 7'h3A;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, en = 1'b0, str_en = 1'b1, ten_bit = 1'b0, gc_en = 1'b0, acc_all = 1'b0;
  logic [9:0] own_addr = {3'b000, OWN7};
  logic sw_set = 1'b0, sw_clr = 1'b0, host_set = 1'b0, auto_rel = 1'b1;
  logic [7:0] tx_byte = 8'hFF;
  logic m_scl_lo = 1'b0, m_sda_lo = 1'b0;
  logic scl_oe, sda_oe, rel, rd_mode, rx_done, tx_load, addr_hit, gc_hit;
  logic [7:0] rx_byte;
  logic scl, sda, rel_set;
  assign scl = !(m_scl_lo || scl_oe);
  assign sda = !(m_sda_lo || sda_oe);
  assign rel_set = sw_set | host_set;

  i2c_slave_stretch u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .str_en(str_en), .ten_bit(ten_bit),
    .gc_en(gc_en), .acc_all(acc_all), .own_addr(own_addr), .rel_set(rel_set),
    .rel_clr(sw_clr), .tx_byte(tx_byte), .scl_i(scl), .sda_i(sda),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rel(rel), .rd_mode(rd_mode),
    .rx_byte(rx_byte), .rx_done(rx_done), .tx_load(tx_load),
    .addr_hit(addr_hit), .gc_hit(gc_hit)
  );

  int checks = 0, errors = 0, last_wait = 0;
  int n_rx = 0, n_addr = 0, n_gc = 0, n_tx = 0;
  logic [7:0] last_rx = 8'h00;
  bit done = 0;

  always @(negedge clk) begin
    if (rx_done) begin n_rx++; last_rx = rx_byte; end
    if (addr_hit) n_addr++;
    if (gc_hit) n_gc++;
    if (tx_load) n_tx++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  initial forever begin
    @(negedge clk);
    if (auto_rel && en && !rel) begin
      wt(60); host_set = 1'b1; @(negedge clk); host_set = 1'b0;
    end
  end

  task automatic scl_up();
    int w = 0;
    m_scl_lo = 1'b0;
    @(negedge clk);
    while (!scl && w < 5000) begin w++; @(negedge clk); end
    last_wait = w;
  endtask

  task automatic scl_dn(); m_scl_lo = 1'b1; wt(5); endtask

  task automatic start();
    m_sda_lo = 1'b0; wt(H); scl_up(); wt(H);
    m_sda_lo = 1'b1; wt(H); scl_dn(); wt(H);
  endtask

  task automatic stop(output int w);
    m_sda_lo = 1'b1; wt(H); scl_up(); w = last_wait; wt(H);
    m_sda_lo = 1'b0; wt(H);
  endtask

  task automatic wr(input logic [7:0] b, input int nb, output bit ack, output int w0);
    ack = 0; w0 = 0;
    for (int i = 7; i >= 8 - nb; i--) begin
      m_sda_lo = !b[i]; wt(H); scl_up(); if (i == 7) w0 = last_wait; wt(H); scl_dn();
    end
    if (nb == 8) begin
      m_sda_lo = 1'b0; wt(H); scl_up(); wt(H/2); ack = !sda; wt(H/2); scl_dn();
    end
  endtask

  task automatic rd(input bit mack, output logic [7:0] b, output int w0);
    m_sda_lo = 1'b0; w0 = 0;
    for (int i = 7; i >= 0; i--) begin
      wt(H); scl_up(); if (i == 7) w0 = last_wait; wt(H/2); b[i] = sda; wt(H/2); scl_dn();
    end
    m_sda_lo = mack; wt(H); scl_up(); wt(H); scl_dn();
  endtask

  function automatic bit exp_ack7(logic [7:0] b, bit gce);
    return b[7:1] == OWN7 || (gce && b == 8'h00);
  endfunction

  initial begin
    bit ack; int w, ws; int r0, a0, g0, t0; logic [7:0] b, d; int dummy;
    dummy = $urandom(32'h5EED);
    wt(3); rst_n = 1'b1; wt(2);
    chk(rel == 1 && scl_oe == 0 && sda_oe == 0, "R1 reset", {rel, scl_oe, sda_oe}, 3'b100);
    en = 1'b1; wt(4);

    auto_rel = 1'b0;
    @(negedge clk) sw_clr = 1; @(negedge clk) sw_clr = 0; wt(6);
    chk(rel == 0, "R4 sw clear", rel, 0);
    chk(scl_oe == 0, "R3 no pull while scl high", scl_oe, 0);
    @(negedge clk) sw_set = 1; @(negedge clk) sw_set = 0; wt(2);
    chk(rel == 1 && scl_oe == 0, "R4/R2 sw set", {rel, scl_oe}, 2'b10);
    str_en = 1'b0;
    @(negedge clk) sw_clr = 1; @(negedge clk) sw_clr = 0; wt(2);
    chk(rel == 1, "R5 clear ignored", rel, 1);
    str_en = 1'b1; auto_rel = 1'b1;

    // 7-bit write, stretch mode on
    start(); wr({OWN7, 1'b0}, 8, ack, w);
    chk(ack, "R8 own addr ack", ack, 1);
    chk(n_addr == 1, "R8 addr_hit", n_addr, 1);
    wr(8'hC5, 8, ack, w);
    chk(w > 30, "R6 stretch after addr", w, 31);
    chk(ack && n_rx == 1 && last_rx == 8'hC5, "R12 rx byte", last_rx, 8'hC5);
    stop(ws);
    chk(ws > 30, "R7 stretch after data str_en=1", ws, 31);

    // stretch mode off
    str_en = 1'b0;
    start(); wr({OWN7, 1'b0}, 8, ack, w); wr(8'h3E, 8, ack, w);
    chk(w > 30, "R6 addr stretch str_en=0", w, 31);
    chk(ack && last_rx == 8'h3E, "R12 rx byte 2", last_rx, 8'h3E);
    chk(rel == 1, "R7 rel kept str_en=0", rel, 1);
    stop(ws);
    chk(ws == 0, "R7 no stretch after data", ws, 0);
    str_en = 1'b1;

    // mismatch
    r0 = n_rx; a0 = n_addr;
    start(); wr(8'h52, 8, ack, w);
    chk(!ack, "R8 mismatch nack", ack, 0);
    wr({OWN7, 1'b0}, 8, ack, w);
    chk(!ack && n_rx == r0 && n_addr == a0, "R8 ignored until stop", ack, 0);
    stop(ws);

    // general call
    gc_en = 1'b1; g0 = n_gc;
    start(); wr(8'h00, 8, ack, w);
    chk(ack && n_gc == g0 + 1, "R10 gc accepted", n_gc - g0, 1);
    wr(8'h11, 8, ack, w);
    chk(ack && last_rx == 8'h11, "R10 gc data", last_rx, 8'h11);
    stop(ws);
    gc_en = 1'b0;
    start(); wr(8'h00, 8, ack, w);
    chk(!ack && n_gc == g0 + 1, "R10 gc ignored", ack, 0);
    stop(ws);

    // accept all
    acc_all = 1'b1;
    start(); wr(8'h52, 8, ack, w);
    chk(ack, "R11 accept all", ack, 1);
    wr(8'h9D, 8, ack, w);
    chk(ack && last_rx == 8'h9D, "R11 data", last_rx, 8'h9D);
    stop(ws);
    acc_all = 1'b0;

    // transmit
    t0 = n_tx; tx_byte = 8'hA6;
    start(); wr({OWN7, 1'b1}, 8, ack, w);
    chk(ack && rd_mode, "R13 read addr", {ack, rd_mode}, 2'b11);
    rd(1'b1, b, w);
    chk(w > 30, "R6 stretch before tx byte", w, 31);
    chk(b == 8'hA6, "R13 tx byte 1", b, 8'hA6);
    tx_byte = 8'h3C;
    rd(1'b0, d, w);
    chk(d == 8'h3C, "R13 tx byte 2", d, 8'h3C);
    chk(n_tx == t0 + 2, "R13 tx_load count", n_tx - t0, 2);
    wt(10);
    chk(!rd_mode && !sda_oe, "R13 nack ends tx", {rd_mode, sda_oe}, 0);
    stop(ws);

    // 10-bit
    ten_bit = 1'b1; own_addr = 10'h2B5; a0 = n_addr;
    start(); wr(8'hF4, 8, ack, w);
    chk(ack && n_addr == a0, "R9 header ack", ack, 1);
    wr(8'hB5, 8, ack, w);
    chk(ack && n_addr == a0 + 1, "R9 low byte match", n_addr - a0, 1);
    wr(8'h5A, 8, ack, w);
    chk(ack && last_rx == 8'h5A, "R9 data", last_rx, 8'h5A);
    tx_byte = 8'h96;
    start(); wr(8'hF5, 8, ack, w);
    chk(ack && rd_mode, "R9 restart read", {ack, rd_mode}, 2'b11);
    rd(1'b0, b, w);
    chk(b == 8'h96, "R9 tx byte", b, 8'h96);
    stop(ws);
    start(); wr(8'hF4, 8, ack, w); wr(8'hB4, 8, ack, w);
    chk(!ack, "R9 low byte mismatch", ack, 0);
    stop(ws);
    ten_bit = 1'b0; own_addr = {3'b000, OWN7};

    // abort mid-byte
    r0 = n_rx;
    start(); wr({OWN7, 1'b0}, 8, ack, w); wr(8'hFF, 4, ack, w);
    start(); wr({OWN7, 1'b0}, 8, ack, w);
    chk(ack && n_rx == r0, "R14 restart mid byte", n_rx - r0, 0);
    wr(8'h66, 8, ack, w);
    chk(last_rx == 8'h66 && n_rx == r0 + 1, "R14 data after restart", last_rx, 8'h66);
    stop(ws);
    chk(!rd_mode && !sda_oe, "R14 stop idle", {rd_mode, sda_oe}, 0);

    // disable during stretch
    start(); wr({OWN7, 1'b0}, 8, ack, w); wt(40);
    chk(scl_oe == 1 && rel == 0, "R6 holding scl", {scl_oe, rel}, 2'b10);
    en = 1'b0; wt(2);
    chk(!scl_oe && !sda_oe && rel, "R1 disable frees bus", {scl_oe, sda_oe, rel}, 3'b001);
    en = 1'b1; wt(2); stop(ws);

    // constrained random 7-bit writes
    for (int k = 0; k < 10; k++) begin
      logic [7:0] a;
      bit e;
      gc_en = $urandom_range(0, 1);
      case ($urandom_range(0, 2))
        0: a = {OWN7, 1'b0};
        1: a = 8'h00;
        default: a = {7'($urandom), 1'b0};
      endcase
      d = 8'($urandom); e = exp_ack7(a, gc_en); r0 = n_rx;
      start(); wr(a, 8, ack, w);
      chk(ack == e, "R8 random addr", ack, e);
      wr(d, 8, ack, w);
      chk(e ? (last_rx == d && n_rx == r0 + 1) : (n_rx == r0), "R12 random data", last_rx, d);
      stop(ws);
    end
    gc_en = 1'b0;

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule